// File: doc/BRIEF.md
# Daisy-Chained Shift Register I/O Scanner

This block refreshes one chain of serial-in/parallel-out output registers and one chain of parallel-in/serial-out input registers. Both chains share one serial clock, and one scan serves both. Software sees an output byte array and an input byte array, with one byte per register. Byte 0 is the register wired nearest the controller. In both arrays, bit 0 of a byte is software pin 0 of that register. This means an input byte can be written straight into an output byte and keep the same software pin numbering.

A scan starts with a `start` pulse. The block snapshots the output array and pulses the input load strobe low. It then clocks 8×N bits through both chains, where N is the run-time chain length. After that it pulses the output latch strobe once and commits the captured input bytes as a whole. `done` marks the end of the scan. The serial clock runs at a programmable fraction of the system clock. Output data changes on the falling serial-clock edge, and input data is sampled at the rising edge.

The two chains shift in opposite orders. Output bytes are sent starting from the highest register and ending with register 0, each byte LSB first. Input bytes are read starting from register 0, each byte MSB first. As a result, software output pin 0 of a register appears on that register's physical output D7.

Top module: `sr_chain_scanner`

## Requirements
- R1: After a scan, bit b of output byte r appears on physical output D(7−b) of output register r. The bytes are shifted in the order r = N−1 down to 0, each LSB first, so the first bit sent ends on D7 of the farthest register.
- R2: After a scan, input byte r holds physical inputs D0..D7 of input register r in bits 0..7. The serial stream is read from register 0 first, MSB (D7) first.
- R3: The chain length `cfg_len` is sampled at start, in the range 1 to MAX_REGS. A value of 0 is treated as 1 and values above the maximum are clamped. Register 0 keeps the same pin mapping for every length.
- R4: `in_load_n` is held low for exactly one serial half-period (cfg_div+1 clocks) before the first rising serial-clock edge, and `ser_clk` stays low the whole time.
- R5: Each serial-clock half-period lasts cfg_div+1 system clocks. A scan has exactly 8×N rising edges. `ser_dout` never changes while `ser_clk` is high.
- R6: After the last shift, `out_latch` goes high exactly once for cfg_div+1 clocks, and `ser_clk` stays low during the pulse.
- R7: `done` is a one-cycle pulse. The input array takes all of its new bytes in the same cycle that `done` rises. `busy` is high from the cycle after an accepted start until `done`.
- R8: Output-array writes made during a scan do not affect that scan. They take effect on the next scan.
- R9: A `start` that arrives while `busy` is high is ignored. No extra scan or clock edge results.
- R10: After reset, `busy`, `done`, `ser_clk`, `out_latch` and `ser_dout` are 0, `in_load_n` is 1, and every input byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | LEN_W | Registers in the chain (1..MAX_REGS) |
| cfg_div | input | DIV_W | Serial half-period minus one, in system clocks |
| wr_en | input | 1 | Write strobe for the output array |
| wr_addr | input | IDX_W | Output byte index |
| wr_data | input | 8 | Output byte value |
| rd_addr | input | IDX_W | Input byte index |
| rd_data | output | 8 | Committed input byte |
| start | input | 1 | Scan request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| ser_clk | output | 1 | Shared serial clock |
| ser_dout | output | 1 | Serial data to output chain |
| ser_din | input | 1 | Serial data from input chain |
| out_latch | output | 1 | Output register latch strobe |
| in_load_n | output | 1 | Input register parallel-load strobe, active low |

## Verification
The assertions assume that `cfg_len` and `cfg_div` hold steady for the whole of a scan. They also assume that no output write lands in the same cycle as the start it should precede. The bench changes configuration only while the block is idle, and it issues writes either well before a start or in the middle of a scan. The serial input is produced by a model of an input-register chain. That model reloads on the falling edge of `in_load_n` and advances on the rising edge of `ser_clk`. This holds `ser_din` stable between the edges where the block samples it.

// File: rtl/sr_scan_pkg.sv
package sr_scan_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_LOW,
      ST_HIGH,
      ST_LATCH
   } scan_st_t;
endpackage

// File: rtl/sr_tick_gen.sv
module sr_tick_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (cnt == limit)   cnt <= '0;
      else                     cnt <= cnt + DIV_W'(1);
   end

   assign tick = run && (cnt == limit);

   // R5
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && limit != '0) |=> !tick);
endmodule

// File: rtl/sr_out_bank.sv
module sr_out_bank #(
   parameter int MAX_REGS = 16,
   localparam int IDX_W = $clog2(MAX_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             snap,
   input  logic [IDX_W-1:0] sel_reg,
   input  logic [2:0]       sel_bit,
   output logic             bit_out
);
   logic [MAX_REGS-1:0][7:0] live;
   logic [MAX_REGS-1:0][7:0] shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live   <= '0;
         shadow <= '0;
      end else begin
         for (int i = 0; i < MAX_REGS; i++) begin
            if (wr_en && wr_addr == IDX_W'(i)) live[i] <= wr_data;
         end
         if (snap) shadow <= live;
      end
   end

   assign bit_out = shadow[sel_reg][sel_bit];

   // R8
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(shadow));
endmodule

// File: rtl/sr_in_bank.sv
module sr_in_bank #(
   parameter int MAX_REGS = 16,
   localparam int IDX_W = $clog2(MAX_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [IDX_W-1:0] cap_reg,
   input  logic [2:0]       cap_bit,
   input  logic             cap_val,
   input  logic             commit,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [7:0]       rd_data
);
   logic [MAX_REGS-1:0][7:0] cap;
   logic [MAX_REGS-1:0][7:0] arr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap <= '0;
         arr <= '0;
      end else begin
         if (cap_en) cap[cap_reg][cap_bit] <= cap_val;
         if (commit) arr <= cap;
      end
   end

   assign rd_data = arr[rd_addr];

   // R7
   commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(arr));
endmodule

// File: rtl/sr_chain_scanner.sv
module sr_chain_scanner
   import sr_scan_pkg::*;
#(
   parameter int MAX_REGS = 16,
   parameter int DIV_W    = 8,
   localparam int IDX_W   = $clog2(MAX_REGS),
   localparam int LEN_W   = $clog2(MAX_REGS + 1),
   localparam int CNT_W   = IDX_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [7:0]       rd_data,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             ser_clk,
   output logic             ser_dout,
   input  logic             ser_din,
   output logic             out_latch,
   output logic             in_load_n
);
   if (MAX_REGS < 2 || (MAX_REGS & (MAX_REGS - 1)) != 0) begin : g_bad_regs
      $error("MAX_REGS must be a power of two of at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   scan_st_t         state;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] lenm1_q;
   logic [LEN_W-1:0] len_eff;
   logic [CNT_W-1:0] oidx;
   logic             tick, out_bit, last_bit, snap, cap_en, commit;

   always_comb begin
      if (cfg_len == '0)                      len_eff = LEN_W'(1);
      else if (cfg_len > LEN_W'(MAX_REGS))    len_eff = LEN_W'(MAX_REGS);
      else                                    len_eff = cfg_len;
   end

   assign busy     = (state != ST_IDLE);
   assign snap     = (state == ST_IDLE) && start;
   assign cap_en   = (state == ST_LOW) && tick;
   assign commit   = (state == ST_LATCH) && tick;
   assign oidx     = (state == ST_HIGH) ? cnt + CNT_W'(1) : cnt;
   assign last_bit = (cnt[CNT_W-1:3] == lenm1_q) && (&cnt[2:0]);

   sr_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .limit(cfg_div), .tick(tick));

   sr_out_bank #(.MAX_REGS(MAX_REGS)) u_out (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .snap(snap),
      .sel_reg(lenm1_q - oidx[CNT_W-1:3]), .sel_bit(oidx[2:0]),
      .bit_out(out_bit));

   sr_in_bank #(.MAX_REGS(MAX_REGS)) u_in (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
      .cap_reg(cnt[CNT_W-1:3]), .cap_bit(~cnt[2:0]), .cap_val(ser_din),
      .commit(commit), .rd_addr(rd_addr), .rd_data(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         lenm1_q   <= '0;
         ser_clk   <= 1'b0;
         ser_dout  <= 1'b0;
         in_load_n <= 1'b1;
         out_latch <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state     <= ST_LOAD;
               lenm1_q   <= IDX_W'(len_eff - LEN_W'(1));
               cnt       <= '0;
               in_load_n <= 1'b0;
            end
            ST_LOAD: if (tick) begin
               in_load_n <= 1'b1;
               ser_dout  <= out_bit;
               state     <= ST_LOW;
            end
            ST_LOW: if (tick) begin
               ser_clk <= 1'b1;
               state   <= ST_HIGH;
            end
            ST_HIGH: if (tick) begin
               ser_clk <= 1'b0;
               if (last_bit) begin
                  out_latch <= 1'b1;
                  state     <= ST_LATCH;
               end else begin
                  cnt      <= cnt + CNT_W'(1);
                  ser_dout <= out_bit;
                  state    <= ST_LOW;
               end
            end
            ST_LATCH: if (tick) begin
               out_latch <= 1'b0;
               done      <= 1'b1;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && in_load_n && !out_latch));
   // R5
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_dout));
   // R6
   latch_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_latch |-> !ser_clk);
   // R4
   load_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_load_n |-> !ser_clk);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ((busy || done) && $stable(lenm1_q)));
endmodule

// File: tb/tb_sr_chain_scanner.sv
module tb_sr_chain_scanner;
   localparam int MAXR = 16;
   localparam int NB   = MAXR * 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] cfg_len = 5'd1;
   logic [7:0] cfg_div = 8'd0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       start = 1'b0;
   logic       busy, done, ser_clk, ser_dout, ser_din, out_latch, in_load_n;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sr_chain_scanner #(.MAX_REGS(MAXR), .DIV_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_div(cfg_div),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .busy(busy),
      .done(done), .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_din(ser_din),
      .out_latch(out_latch), .in_load_n(in_load_n));

   // chain models: physical index 8*reg + D
   logic [NB-1:0] in_pins = '0;
   logic [NB-1:0] out_sh  = '0;
   logic [NB-1:0] out_pins = '0;
   logic [7:0]    ptr = '0;

   always @(posedge ser_clk or negedge in_load_n)
      if (!in_load_n) ptr <= '0;
      else            ptr <= ptr + 8'd1;
   assign ser_din = in_pins[{ptr[6:3], ~ptr[2:0]}];
   always @(posedge ser_clk) out_sh <= {out_sh[NB-2:0], ser_dout};
   always @(posedge out_latch) out_pins <= out_sh;

   // monitors
   logic mon_clr = 1'b0;
   int hi_cyc, rises, lat_p, lat_cyc, load_cyc, bad_edge, done_cnt;
   logic p_sclk, p_lat, p_dout;
   always @(negedge clk) begin
      if (mon_clr) begin
         hi_cyc = 0; rises = 0; lat_p = 0; lat_cyc = 0;
         load_cyc = 0; bad_edge = 0; done_cnt = 0;
      end else begin
         if (ser_clk) hi_cyc++;
         if (ser_clk && !p_sclk) rises++;
         if (out_latch && !p_lat) lat_p++;
         if (out_latch) lat_cyc++;
         if (!in_load_n) load_cyc++;
         if (ser_clk && p_sclk && ser_dout != p_dout) bad_edge++;
         if (!in_load_n && ser_clk) bad_edge++;
         if (done) done_cnt++;
      end
      p_sclk = ser_clk; p_lat = out_latch; p_dout = ser_dout;
   end

   function automatic logic [7:0] rev8(input logic [7:0] v);
      for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      @(posedge clk) mon_clr = 1'b1;
      @(posedge clk) mon_clr = 1'b0;
   endtask

   task automatic write_out(input int r, input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(r); wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_in(input int r, output logic [7:0] v);
      @(negedge clk);
      rd_addr = 4'(r);
      #1 v = rd_data;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int t = 0;
      while (!done && t < 20000) begin @(negedge clk); t++; end
      chk(done == 1'b1, req, done, 1);
   endtask

   task automatic scan(input int len, input int div);
      @(negedge clk);
      cfg_len = 5'(len); cfg_div = 8'(div);
      clear_mon();
      pulse_start();
      wait_done("R7 done reached");
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk(!busy && !done && !ser_clk && !out_latch && !ser_dout && in_load_n,
          "R10 reset outputs", {busy, done, ser_clk, out_latch, ser_dout, in_load_n}, 1);
      read_in(3, v);
      chk(v == 8'h00, "R10 input array cleared", v, 0);
   endtask

   task automatic t_order(input int len, input int div, input int seed);
      logic [7:0] ov [MAXR];
      logic [7:0] v;
      for (int r = 0; r < MAXR; r++) begin
         ov[r] = 8'((r * 29 + seed) ^ (seed << 3));
         in_pins[8*r +: 8] = 8'((r * 37 + seed * 5) ^ 8'h93);
      end
      for (int r = 0; r < len; r++) write_out(r, ov[r]);
      scan(len, div);
      for (int r = 0; r < len; r++) begin
         chk(out_pins[8*r +: 8] == rev8(ov[r]), "R1 output pin mapping",
             out_pins[8*r +: 8], rev8(ov[r]));
         read_in(r, v);
         chk(v == in_pins[8*r +: 8], "R2 input pin mapping", v, in_pins[8*r +: 8]);
      end
      chk(rises == 8 * len, "R5 rising edge count", rises, 8 * len);
      chk(done_cnt == 1, "R7 single done", done_cnt, 1);
   endtask

   task automatic t_timing();
      t_order(2, 3, 11);
      chk(hi_cyc == 16 * 4, "R5 high time", hi_cyc, 64);
      chk(bad_edge == 0, "R5 dout stable while high", bad_edge, 0);
      chk(load_cyc == 4, "R4 load strobe width", load_cyc, 4);
      chk(lat_p == 1, "R6 latch pulse count", lat_p, 1);
      chk(lat_cyc == 4, "R6 latch width", lat_cyc, 4);
   endtask

   task automatic t_length();
      logic [7:0] v;
      t_order(4, 0, 3);
      in_pins[7:0] = 8'hC1;
      write_out(0, 8'h0F);
      scan(1, 1);
      chk(out_pins[7:0] == 8'hF0, "R3 reg0 mapping at length 1", out_pins[7:0], 8'hF0);
      read_in(0, v);
      chk(v == 8'hC1, "R3 reg0 input at length 1", v, 8'hC1);
      scan(0, 0);
      chk(rises == 8, "R3 zero length clamps to 1", rises, 8);
      scan(31, 0);
      chk(rises == 8 * MAXR, "R3 long length clamps", rises, 8 * MAXR);
   endtask

   task automatic t_write_mid();
      write_out(0, 8'hA1);
      @(negedge clk);
      cfg_len = 5'd1; cfg_div = 8'd2;
      clear_mon();
      pulse_start();
      repeat (10) @(negedge clk);
      write_out(0, 8'h3C);
      wait_done("R8 done reached");
      @(negedge clk);
      chk(out_pins[7:0] == rev8(8'hA1), "R8 mid-scan write deferred", out_pins[7:0], rev8(8'hA1));
      scan(1, 2);
      chk(out_pins[7:0] == rev8(8'h3C), "R8 write used next scan", out_pins[7:0], rev8(8'h3C));
   endtask

   task automatic t_start_busy();
      @(negedge clk);
      cfg_len = 5'd2; cfg_div = 8'd1;
      clear_mon();
      pulse_start();
      chk(busy == 1'b1, "R7 busy after start", busy, 1);
      repeat (7) @(negedge clk);
      pulse_start();
      wait_done("R9 done reached");
      repeat (60) @(negedge clk);
      chk(rises == 16, "R9 no extra edges", rises, 16);
      chk(done_cnt == 1, "R9 no second scan", done_cnt, 1);
      chk(busy == 1'b0, "R9 idle after scan", busy, 0);
   endtask

   initial begin
      #3000000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order(2, 0, 1);
      t_order(16, 0, 7);
      t_order(5, 2, 42);
      t_timing();
      t_length();
      t_write_mid();
      t_start_busy();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule